// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the slave side of a two-wire serial memory. It samples the clock and data lines through the system clock, cleans them up, and finds START and STOP conditions and clock edges. It then runs the byte protocol. It takes in a control byte and checks the device code and the chip-select field against the strap pins. It pulls the data line low to acknowledge. On writes it passes on the word address and the data bytes. On reads it shifts out the bytes that the memory core supplies.

There are two device codes. The array code allows reads and writes. The protect code allows writes only, and a read request on that code gets no acknowledge. While the core reports an internal write cycle, the block stays silent on every byte. The memory core receives the operation type, a bus-active flag and one-cycle strobes for the address, for each data byte and for each read byte taken.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset, `bus_active` is 0, `sda_pull` is 0, `op_kind` is 0 and no strobe is high.
- R2: A falling data line while the clock is high sets `bus_active` to 1. A rising data line while the clock is high clears `bus_active`, releases the data line and returns `op_kind` to 0.
- R3: A control byte is taken MSB first. It is read as bits 7..4 device code, bits 3..1 chip select and bit 0 read (1) or write (0). Code 1010 with a matching chip select is acknowledged: the data line is held low through the whole high phase of the ninth clock. `op_kind` becomes 1 for a write and 2 for a read.
- R4: Code 0110 with a matching chip select and the write bit is acknowledged, and `op_kind` becomes 3.
- R5: A control byte with any other code, or with a chip select that differs from `chip_sel`, is not acknowledged. Later bytes up to the next START are neither acknowledged nor strobed.
- R6: A read request with code 0110 is not acknowledged, even when the chip select matches.
- R7: While `core_busy` is 1, no byte is acknowledged and no address or data strobe is given.
- R8: On a write, the first byte after the control byte pulses `addr_stb` and later bytes pulse `data_stb`. Each is taken MSB first, shown on `rx_byte` and acknowledged.
- R9: On a read, each byte is loaded from `rd_byte` with one `rd_take` pulse and driven MSB first. A master acknowledge fetches the next byte. A master not-acknowledge leaves the data line released until STOP.
- R10: A repeated START without a STOP returns the block to control-byte reception, so the next byte is decoded as a control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_pull | output | 1 | 1 pulls the data line low (open drain) |
| chip_sel | input | 3 | Strap pins compared with the chip-select field |
| core_busy | input | 1 | Internal write cycle in progress |
| rd_byte | input | 8 | Byte the core offers for the next read |
| rx_byte | output | 8 | Last accepted address or data byte |
| addr_stb | output | 1 | One-cycle pulse: word address received |
| data_stb | output | 1 | One-cycle pulse: write data byte received |
| rd_take | output | 1 | One-cycle pulse: `rd_byte` loaded for sending |
| op_kind | output | 2 | 0 none, 1 array write, 2 array read, 3 protect write |
| bus_active | output | 1 | High between START and STOP |

## Verification
A table of control bytes covers the matching array and protect codes, a read on the protect code, a wrong code, two chip-select mismatches and both valid codes with the core busy. For each one the bench records whether the ninth clock is acknowledged, which operation is reported, and whether the following byte is taken as an address or ignored. These cases separate the code check, the chip-select check, the read-on-protect refusal and the busy check from one another. Directed sequences then cover a full write with distinct bit patterns, a core that becomes busy partway through, a two-byte read ending in a not-acknowledge, and a repeated START. Together they show bit order, the address/data sequencing, read-byte fetching, release of the line after the master declines, and reentry into control-byte decoding.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam logic [3:0] CODE_ARRAY = 4'b1010;
  localparam logic [3:0] CODE_GUARD = 4'b0110;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_AWR  = 2'd1,
    OP_ARD  = 2'd2,
    OP_PWR  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_ACKW, S_ACK, S_TX, S_MACK, S_MACKF, S_SKIP
  } st_e;

  typedef enum logic [1:0] {
    K_CTRL, K_ADDR, K_DATA
  } kind_e;
endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_TAPS   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_out
);
  localparam int HALF = VOTE_TAPS / 2;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [VOTE_TAPS-1:0]   hist_q, hist_d;
  logic                   level_q, level_d;
  int                     vote_cnt;

  always_comb begin
    sync_d   = {sync_q[SYNC_STAGES-2:0], line_in};
    hist_d   = {hist_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
    vote_cnt = 0;
    for (int i = 0; i < VOTE_TAPS; i++) vote_cnt = vote_cnt + int'(hist_q[i]);
    level_d  = (vote_cnt > HALF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      hist_q  <= '1;
      level_q <= 1'b1;
    end else begin
      sync_q  <= sync_d;
      hist_q  <= hist_d;
      level_q <= level_d;
    end
  end

  assign line_out = level_q;

  // R2: a filtered level flip is always led by the newest synchronized sample
  p_vote_newest_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != $past(level_q)) |-> (level_q == $past(hist_q[0])));
endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_p,
  output logic stop_p,
  output logic rise_p,
  output logic fall_p
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  always_comb begin
    start_p = scl_f & scl_q & sda_q & ~sda_f;
    stop_p  = scl_f & scl_q & ~sda_q & sda_f;
    rise_p  = scl_f & ~scl_q;
    fall_p  = ~scl_f & scl_q;
  end

  // R2: bus conditions only occur with the clock held high
  p_cond_scl_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_p || stop_p) |-> (scl_q && !rise_p && !fall_p));
endmodule

// File: rtl/twi_byte_engine.sv
module twi_byte_engine
  import twi_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic              rise_p,
  input  logic              fall_p,
  input  logic              sda_f,
  input  logic [SEL_W-1:0]  chip_sel,
  input  logic              core_busy,
  input  logic [DATA_W-1:0] rd_byte,
  output logic              sda_pull,
  output logic [DATA_W-1:0] rx_byte,
  output logic              addr_stb,
  output logic              data_stb,
  output logic              rd_take,
  output logic [1:0]        op_kind,
  output logic              bus_active
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  st_e               st_q, st_d;
  kind_e             kind_q, kind_d;
  op_e               op_q, op_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d, rxb_q, rxb_d, full;
  logic              pull_q, pull_d, ack_q, ack_d, act_q, act_d;
  logic              astb_q, astb_d, dstb_q, dstb_d, take_q, take_d;
  logic [3:0]        f_code;
  logic [SEL_W-1:0]  f_sel;
  logic              f_rw, ctrl_ok;

  always_comb begin
    full    = {sh_q[DATA_W-2:0], sda_f};
    f_code  = full[DATA_W-1 -: 4];
    f_sel   = full[SEL_W:1];
    f_rw    = full[0];
    ctrl_ok = (f_sel == chip_sel) && !core_busy &&
              ((f_code == CODE_ARRAY) || ((f_code == CODE_GUARD) && !f_rw));
  end

  always_comb begin
    st_d   = st_q;   kind_d = kind_q; op_d  = op_q;  cnt_d = cnt_q;
    sh_d   = sh_q;   rxb_d  = rxb_q;  pull_d = pull_q;
    ack_d  = ack_q;  act_d  = act_q;
    astb_d = 1'b0;   dstb_d = 1'b0;   take_d = 1'b0;
    if (stop_p) begin
      st_d = S_IDLE; pull_d = 1'b0; op_d = OP_NONE; act_d = 1'b0;
    end else if (start_p) begin
      st_d = S_RX; kind_d = K_CTRL; cnt_d = '0; pull_d = 1'b0;
      op_d = OP_NONE; act_d = 1'b1;
    end else begin
      unique case (st_q)
        S_RX: if (rise_p) begin
          sh_d = full;
          if (cnt_q == LAST) begin
            cnt_d = '0;
            st_d  = S_ACKW;
            unique case (kind_q)
              K_CTRL: begin
                ack_d = ctrl_ok;
                if (ctrl_ok) begin
                  if (f_code == CODE_GUARD) op_d = OP_PWR;
                  else                      op_d = f_rw ? OP_ARD : OP_AWR;
                end
              end
              K_ADDR: begin
                ack_d = !core_busy; astb_d = !core_busy;
                if (!core_busy) rxb_d = full;
              end
              default: begin
                ack_d = !core_busy; dstb_d = !core_busy;
                if (!core_busy) rxb_d = full;
              end
            endcase
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        S_ACKW: if (fall_p) begin
          pull_d = ack_q;
          st_d   = S_ACK;
        end
        S_ACK: if (fall_p) begin
          pull_d = 1'b0;
          if (!ack_q) begin
            st_d = S_SKIP;
          end else if ((kind_q == K_CTRL) && (op_q == OP_ARD)) begin
            sh_d = rd_byte; pull_d = !rd_byte[DATA_W-1];
            cnt_d = '0; take_d = 1'b1; st_d = S_TX;
          end else begin
            st_d   = S_RX;
            kind_d = (kind_q == K_CTRL) ? K_ADDR : K_DATA;
          end
        end
        S_TX: if (fall_p) begin
          if (cnt_q == LAST) begin
            pull_d = 1'b0; cnt_d = '0; st_d = S_MACK;
          end else begin
            cnt_d  = cnt_q + 1'b1;
            pull_d = !sh_q[DATA_W-2];
            sh_d   = {sh_q[DATA_W-2:0], 1'b0};
          end
        end
        S_MACK: if (rise_p) st_d = sda_f ? S_SKIP : S_MACKF;
        S_MACKF: if (fall_p) begin
          sh_d = rd_byte; pull_d = !rd_byte[DATA_W-1];
          cnt_d = '0; take_d = 1'b1; st_d = S_TX;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; kind_q <= K_CTRL; op_q <= OP_NONE; cnt_q <= '0;
      sh_q <= '0; rxb_q <= '0; pull_q <= 1'b0; ack_q <= 1'b0; act_q <= 1'b0;
      astb_q <= 1'b0; dstb_q <= 1'b0; take_q <= 1'b0;
    end else begin
      st_q <= st_d; kind_q <= kind_d; op_q <= op_d; cnt_q <= cnt_d;
      sh_q <= sh_d; rxb_q <= rxb_d; pull_q <= pull_d; ack_q <= ack_d; act_q <= act_d;
      astb_q <= astb_d; dstb_q <= dstb_d; take_q <= take_d;
    end
  end

  assign sda_pull   = pull_q;
  assign rx_byte    = rxb_q;
  assign addr_stb   = astb_q;
  assign data_stb   = dstb_q;
  assign rd_take    = take_q;
  assign op_kind    = op_q;
  assign bus_active = act_q;

  // R3: the line is only ever pulled low just after a clock fall
  p_pull_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_q) |-> $past(fall_p));
  // R7: no byte strobe is issued while the core reports busy
  p_busy_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (astb_q || dstb_q) |-> !$past(core_busy));
  // R2: STOP leaves the bus idle and the line released
  p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> (!act_q && !pull_q && op_q == OP_NONE));
  // R8: at most one strobe per cycle
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({astb_q, dstb_q, take_q}));
  // R6: only an array read ever transmits
  p_tx_only_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_TX) |-> (op_q == OP_ARD));
  // R10: START always restarts control-byte reception
  p_start_ctrl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_p && !stop_p) |=> (act_q && st_q == S_RX && kind_q == K_CTRL && cnt_q == '0));
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave #(
  parameter int DATA_W      = 8,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_TAPS   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull,
  input  logic [SEL_W-1:0]  chip_sel,
  input  logic              core_busy,
  input  logic [DATA_W-1:0] rd_byte,
  output logic [DATA_W-1:0] rx_byte,
  output logic              addr_stb,
  output logic              data_stb,
  output logic              rd_take,
  output logic [1:0]        op_kind,
  output logic              bus_active
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw, clean;
  logic start_p, stop_p, rise_p, fall_p;

  assign raw = {scl_in, sda_in};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    twi_line_filter #(.SYNC_STAGES(SYNC_STAGES), .VOTE_TAPS(VOTE_TAPS)) u_flt (
      .clk(clk), .rst_n(rst_n), .line_in(raw[g]), .line_out(clean[g]));
  end

  twi_cond_detect u_cond (
    .clk(clk), .rst_n(rst_n), .scl_f(clean[1]), .sda_f(clean[0]),
    .start_p(start_p), .stop_p(stop_p), .rise_p(rise_p), .fall_p(fall_p));

  twi_byte_engine #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start_p(start_p), .stop_p(stop_p),
    .rise_p(rise_p), .fall_p(fall_p), .sda_f(clean[0]),
    .chip_sel(chip_sel), .core_busy(core_busy), .rd_byte(rd_byte),
    .sda_pull(sda_pull), .rx_byte(rx_byte), .addr_stb(addr_stb),
    .data_stb(data_stb), .rd_take(rd_take), .op_kind(op_kind),
    .bus_active(bus_active));
endmodule

// File: tb/sim_twi_mem_slave.sv
module sim_twi_mem_slave;
  localparam int Q = 12;
  localparam logic [2:0] STRAP = 3'b101;
  // {control byte, busy, expected ack, expected op}
  localparam logic [11:0] VEC [0:7] = '{
    12'hAA5, 12'h6A7, 12'h6B0, 12'hA80, 12'h5A0, 12'hAA8, 12'h6A8, 12'hA20 };

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, busy = 1'b0;
  logic sda_pull, addr_stb, data_stb, rd_take, bus_active;
  logic [7:0] rx_byte, rd_byte, ptr = 8'd0, last_rx = 8'd0;
  logic [1:0] op_kind;
  logic sda_line;
  int n_chk = 0, n_bad = 0, n_addr = 0, n_data = 0, n_take = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  assign sda_line = m_sda & ~sda_pull;
  assign rd_byte  = 8'hC3 + ptr * 8'h25;

  twi_mem_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .sda_pull(sda_pull), .chip_sel(STRAP), .core_busy(busy), .rd_byte(rd_byte),
    .rx_byte(rx_byte), .addr_stb(addr_stb), .data_stb(data_stb),
    .rd_take(rd_take), .op_kind(op_kind), .bus_active(bus_active));

  always @(posedge clk) if (rst_n) begin
    if (addr_stb) begin n_addr <= n_addr + 1; last_rx <= rx_byte; end
    if (data_stb) begin n_data <= n_data + 1; last_rx <= rx_byte; end
    if (rd_take)  begin n_take <= n_take + 1; ptr <= ptr + 8'd1; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    logic s1, s2;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(Q); m_scl = 1'b1; wq(2 * Q); m_scl = 1'b0; wq(Q);
    end
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(1);
    s1 = sda_line; wq(2 * Q - 2); s2 = sda_line; wq(1);
    m_scl = 1'b0; wq(Q);
    acked = !s1 && !s2;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); m_scl = 1'b1; wq(Q); b[i] = sda_line; wq(Q); m_scl = 1'b0;
    end
    wq(Q); m_sda = !mack; wq(Q); m_scl = 1'b1; wq(2 * Q); m_scl = 1'b0; wq(Q);
    m_sda = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit ak;
    logic [7:0] rb;
    int a0;
    wq(5);
    chk(!bus_active && !sda_pull && op_kind == 2'd0, "R1 idle", {bus_active, sda_pull, op_kind}, 0);
    chk(!addr_stb && !data_stb && !rd_take, "R1 strobes", {addr_stb, data_stb, rd_take}, 0);
    rst_n = 1'b1; wq(10);

    // table: control byte decoding
    for (int v = 0; v < 8; v++) begin
      string tg;
      logic [7:0] cb;
      bit eack;
      cb = VEC[v][11:4]; busy = VEC[v][3]; eack = VEC[v][2];
      if (busy) tg = "R7";
      else if (cb[7:4] == 4'b0110 && cb[0]) tg = "R6";
      else if (eack) tg = (cb[7:4] == 4'b1010) ? "R3" : "R4";
      else tg = "R5";
      a0 = n_addr;
      bus_start();
      chk(bus_active, "R2 start", bus_active, 1);
      send_byte(cb, ak);
      chk(ak == eack, {tg, " ack"}, ak, eack);
      chk(op_kind == VEC[v][1:0], {tg, " op"}, op_kind, VEC[v][1:0]);
      send_byte(8'h55, ak);
      chk(ak == eack && n_addr == a0 + int'(eack), {tg, " follow byte"}, n_addr - a0, eack);
      bus_stop(); wq(Q);
      chk(!bus_active && op_kind == 2'd0, "R2 stop", {bus_active, op_kind}, 0);
    end
    busy = 1'b0;

    // full write, MSB-first byte values
    bus_start();
    send_byte(8'hAA, ak);
    send_byte(8'h3C, ak);
    chk(ak && last_rx == 8'h3C, "R8 addr", last_rx, 8'h3C);
    a0 = n_data;
    send_byte(8'h81, ak);
    chk(ak && last_rx == 8'h81, "R8 data0", last_rx, 8'h81);
    send_byte(8'h7E, ak);
    chk(ak && last_rx == 8'h7E && n_data == a0 + 2, "R8 data1", n_data - a0, 2);
    busy = 1'b1;
    send_byte(8'h99, ak);
    chk(!ak && n_data == a0 + 2 && last_rx == 8'h7E, "R7 mid write", {ak, last_rx}, 8'h7E);
    busy = 1'b0;
    bus_stop(); wq(Q);

    // read with ack then nack
    bus_start();
    send_byte(8'hAB, ak);
    chk(ak && op_kind == 2'd2, "R3 read ctrl", op_kind, 2);
    recv_byte(1'b1, rb);
    chk(rb == 8'hC3, "R9 byte0", rb, 8'hC3);
    recv_byte(1'b0, rb);
    chk(rb == 8'hE8, "R9 byte1", rb, 8'hE8);
    wq(2 * Q);
    chk(!sda_pull && sda_line, "R9 released", sda_pull, 0);
    chk(n_take == 2, "R9 takes", n_take, 2);
    bus_stop(); wq(Q);

    // repeated start
    bus_start();
    send_byte(8'hAA, ak);
    send_byte(8'h10, ak);
    a0 = n_addr;
    bus_start();
    send_byte(8'h6A, ak);
    chk(ak && op_kind == 2'd3, "R10 ctrl again", op_kind, 3);
    send_byte(8'h44, ak);
    chk(ak && n_addr == a0 + 1 && last_rx == 8'h44, "R10 addr again", last_rx, 8'h44);
    bus_stop(); wq(Q);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule